// File: doc/BRIEF.md
# Self-Recovering Three-State Controller

This block is a small control sequencer with three states: idle, active and done. A start pulse moves it out of idle. A finish pulse ends the active phase. The done state lasts exactly one cycle and then the controller returns to idle. The inputs are assumed to be synchronous to the clock already.

The state register is guarded against corruption. Every value the register can hold is classified by explicit logic as either a defined state or an undefined pattern. An undefined pattern is overwritten with the idle code on the next clock edge. The idle code is the all-zeros word in the compact encoding. Because the check is a plain comparison on the stored code, and not a default branch of a case statement, synthesis cannot prune it as unreachable.

A parameter selects the encoding: a two-bit compact code or a three-bit one-hot code. Each recovery raises a one-cycle flag and advances a saturating counter. For verification, a fault-injection port can load any pattern into the state register.

Top module: `recovering_fsm`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `state_o` holds the idle code, `recover_o` is 0 and `recover_count` is 0. The idle code is 000 when compact and 100 when one-hot.
- R2: In idle, the controller moves to active on a cycle with `start_i` high and otherwise stays in idle. The active code is 010 in both encodings, as seen on the 3-bit `state_o`.
- R3: In active, the controller moves to done on a cycle with `finish_i` high and otherwise stays in active. The done code is 001 in both encodings.
- R4: Done lasts one cycle and then goes to idle, whatever `start_i` and `finish_i` are.
- R5: In compact mode, the register pattern 11 (seen as `state_o` = 011) is replaced with 00 on the next clock edge.
- R6: In one-hot mode, any pattern that does not have exactly one bit set is replaced with 100 on the next clock edge. This covers 000, 011, 101, 110 and 111.
- R7: `recover_o` is high for exactly the one cycle that follows an edge on which an undefined pattern was replaced. It is low at all other times.
- R8: `recover_count` is 8 bits wide. It increases by one per recovery and stays at 255 once it reaches 255.
- R9: When `inject_en` is high, the next edge loads `inject_value` into the state register. This overrides both the next-state logic and recovery, and counts no recovery. In compact mode, `inject_value[2]` is ignored and `state_o[2]` reads 0.
- R10: Traffic through defined states alone never changes `recover_count` and never raises `recover_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to leave idle |
| finish_i | input | 1 | End of the active phase |
| inject_en | input | 1 | Test only: overwrite the state register on the next edge |
| inject_value | input | 3 | Test only: pattern to load (bit 2 unused in compact mode) |
| state_o | output | 3 | Raw state register, zero-extended in compact mode |
| recover_o | output | 1 | One-cycle pulse after a recovery |
| recover_count | output | 8 | Saturating number of recoveries |

## Verification
Because `state_o` exposes the raw register, a corrupt state shows up at the ports in the same cycle it is stored. The bench uses the injection port to load every undefined pattern. It then expects the idle code, a raised `recover_o` and a counter step exactly one edge later. A missing or late recovery therefore shows up as a wrong `state_o` and a wrong flag on that cycle. A recovery that fires wrongly on a legal code shows up as an extra counter step during normal traffic. Each injected pattern is applied in both encodings, so one pattern can be legal in one encoding and illegal in the other. This separates a wrong legality check from a wrong encoding.

// File: rtl/sfsm_pkg.sv
package sfsm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DONE   = 2'd2
  } sfsm_st_e;

  // one-hot codes: idle 100, active 010, done 001
  function automatic logic [2:0] oh_encode(sfsm_st_e s);
    case (s)
      ST_ACTIVE: oh_encode = 3'b010;
      ST_DONE:   oh_encode = 3'b001;
      default:   oh_encode = 3'b100;
    endcase
  endfunction

  // compact codes: idle 00, active 10, done 01
  function automatic logic [1:0] bin_encode(sfsm_st_e s);
    case (s)
      ST_ACTIVE: bin_encode = 2'b10;
      ST_DONE:   bin_encode = 2'b01;
      default:   bin_encode = 2'b00;
    endcase
  endfunction

  // exactly one bit of three set: odd parity and not all three
  function automatic logic oh_is_legal(logic [2:0] c);
    oh_is_legal = (c[0] ^ c[1] ^ c[2]) & ~(c[0] & c[1] & c[2]);
  endfunction

  function automatic logic bin_is_legal(logic [1:0] c);
    bin_is_legal = ~(c[1] & c[0]);
  endfunction

  function automatic sfsm_st_e step_state(sfsm_st_e s, logic start, logic finish);
    case (s)
      ST_IDLE:   step_state = start  ? ST_ACTIVE : ST_IDLE;
      ST_ACTIVE: step_state = finish ? ST_DONE   : ST_ACTIVE;
      default:   step_state = ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/sfsm_codec.sv
module sfsm_codec
  import sfsm_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0,
  parameter int SW      = ONE_HOT ? 3 : 2
) (
  input  logic [SW-1:0] code,
  input  sfsm_st_e      nxt_st,
  output logic          legal,
  output sfsm_st_e      cur_st,
  output logic [SW-1:0] nxt_code,
  output logic [SW-1:0] idle_code
);

  generate
    if (ONE_HOT) begin : g_onehot
      assign legal     = oh_is_legal(code);
      assign cur_st    = code[1] ? ST_ACTIVE : (code[0] ? ST_DONE : ST_IDLE);
      assign nxt_code  = oh_encode(nxt_st);
      assign idle_code = oh_encode(ST_IDLE);
    end else begin : g_compact
      assign legal     = bin_is_legal(code);
      assign cur_st    = code[1] ? ST_ACTIVE : (code[0] ? ST_DONE : ST_IDLE);
      assign nxt_code  = bin_encode(nxt_st);
      assign idle_code = bin_encode(ST_IDLE);
    end
  endgenerate

endmodule

// File: rtl/sfsm_sat_counter.sv
module sfsm_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  function automatic logic [W-1:0] sat_add(logic [W-1:0] v);
    sat_add = (v == MAXV) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= sat_add(count);
  end

  p_hold_at_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAXV) |=> (count == MAXV));

  p_step_by_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count != MAXV) |=> (count == $past(count) + 1'b1));

  p_idle_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));

endmodule

// File: rtl/recovering_fsm.sv
module recovering_fsm
  import sfsm_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             finish_i,
  input  logic             inject_en,
  input  logic [2:0]       inject_value,
  output logic [2:0]       state_o,
  output logic             recover_o,
  output logic [CNT_W-1:0] recover_count
);

  localparam int SW = ONE_HOT ? 3 : 2;

  logic [SW-1:0] state_q;
  logic [SW-1:0] nxt_code;
  logic [SW-1:0] idle_code;
  logic [SW-1:0] inj_code;
  logic          code_legal;
  logic          recover_evt;
  logic          recover_q;
  sfsm_st_e      cur_st;
  sfsm_st_e      nxt_st;

  sfsm_codec #(.ONE_HOT(ONE_HOT), .SW(SW)) u_codec (
    .code      (state_q),
    .nxt_st    (nxt_st),
    .legal     (code_legal),
    .cur_st    (cur_st),
    .nxt_code  (nxt_code),
    .idle_code (idle_code)
  );

  assign nxt_st      = step_state(cur_st, start_i, finish_i);
  assign recover_evt = ~inject_en & ~code_legal;

  generate
    if (ONE_HOT) begin : g_out3
      assign inj_code = inject_value;
      assign state_o  = state_q;
    end else begin : g_out2
      logic unused_inj_hi;
      assign unused_inj_hi = inject_value[2];
      assign inj_code      = inject_value[1:0];
      assign state_o       = {1'b0, state_q};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= idle_code;
      recover_q <= 1'b0;
    end else begin
      recover_q <= recover_evt;
      if (inject_en)        state_q <= inj_code;
      else if (!code_legal) state_q <= idle_code;
      else                  state_q <= nxt_code;
    end
  end

  assign recover_o = recover_q;

  sfsm_sat_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (recover_evt),
    .count (recover_count)
  );

  p_bad_code_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inject_en && !code_legal) |=> (state_q == idle_code && recover_o));

  p_legal_stays_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inject_en && code_legal) |=> code_legal);

  p_done_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!inject_en && code_legal && cur_st == ST_DONE) |=> (state_q == idle_code));

  p_inject_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inject_en |=> (state_q == $past(inj_code) && !recover_o));

  p_flag_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recover_o |=> !recover_o);

endmodule

// File: tb/recovering_fsm_test.sv
`timescale 1ns/100ps
module recovering_fsm_test;

  typedef struct {
    logic [2:0] st;
    logic       flag;
    int         cnt;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, finish_i = 1'b0, inject_en = 1'b0;
  logic [2:0] inject_value = 3'b000;
  logic [2:0] st_b, st_h;
  logic rec_b, rec_h;
  logic [7:0] cnt_b, cnt_h;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  exp_t q_b[$];
  exp_t q_h[$];

  logic [2:0] m_b = 3'b000, m_h = 3'b100;
  int mc_b = 0, mc_h = 0;

  always #2.5 clk = ~clk;

  recovering_fsm #(.ONE_HOT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .finish_i(finish_i),
    .inject_en(inject_en), .inject_value(inject_value),
    .state_o(st_b), .recover_o(rec_b), .recover_count(cnt_b));

  recovering_fsm #(.ONE_HOT(1'b1)) uut_oh (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .finish_i(finish_i),
    .inject_en(inject_en), .inject_value(inject_value),
    .state_o(st_h), .recover_o(rec_h), .recover_count(cnt_h));

  function automatic bit m_legal(bit oh, logic [2:0] c);
    if (oh) return (c == 3'b100) || (c == 3'b010) || (c == 3'b001);
    return (c == 3'b000) || (c == 3'b010) || (c == 3'b001);
  endfunction

  function automatic logic [2:0] m_idle(bit oh);
    return oh ? 3'b100 : 3'b000;
  endfunction

  function automatic logic [2:0] m_step(bit oh, logic [2:0] c, bit s, bit f);
    if (c == 3'b010) return f ? 3'b001 : 3'b010;
    if (c == 3'b001) return m_idle(oh);
    return s ? 3'b010 : m_idle(oh);
  endfunction

  task automatic check(string what, logic [2:0] st, logic fl, int cn, exp_t e);
    n_checks++;
    if (st !== e.st || fl !== e.flag || cn != e.cnt) begin
      n_fail++;
      $display("FAIL %s [%s]: got state=%b flag=%b count=%0d, expected state=%b flag=%b count=%0d",
               e.tag, what, st, fl, cn, e.st, e.flag, e.cnt);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the result expected after the edge
  task automatic step(bit s, bit f, bit inj, logic [2:0] v, string tag);
    exp_t eb, eh;
    bit fb, fh;
    @(negedge clk);
    start_i = s; finish_i = f; inject_en = inj; inject_value = v;
    fb = !inj && !m_legal(0, m_b);
    fh = !inj && !m_legal(1, m_h);
    m_b = inj ? (v & 3'b011) : (fb ? m_idle(0) : m_step(0, m_b, s, f));
    m_h = inj ? v : (fh ? m_idle(1) : m_step(1, m_h, s, f));
    if (fb && mc_b < 255) mc_b++;
    if (fh && mc_h < 255) mc_h++;
    eb = '{st: m_b, flag: fb, cnt: mc_b, tag: tag};
    eh = '{st: m_h, flag: fh, cnt: mc_h, tag: tag};
    q_b.push_back(eb);
    q_h.push_back(eh);
  endtask

  // monitor: compare after each edge
  always begin
    @(posedge clk);
    #1;
    if (q_b.size() > 0) begin
      exp_t e;
      e = q_b.pop_front();
      check("compact", st_b, rec_b, int'(cnt_b), e);
    end
    if (q_h.size() > 0) begin
      exp_t e;
      e = q_h.pop_front();
      check("onehot", st_h, rec_h, int'(cnt_h), e);
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r = '{st: 3'b000, flag: 1'b0, cnt: 0, tag: "R1 reset"};
    check("compact", st_b, rec_b, int'(cnt_b), r);
    r.st = 3'b100;
    check("onehot", st_h, rec_h, int'(cnt_h), r);
    rst_n = 1'b1;
    @(negedge clk);
    r.tag = "R1 after release";
    check("onehot", st_h, rec_h, int'(cnt_h), r);
    r.st = 3'b000;
    check("compact", st_b, rec_b, int'(cnt_b), r);

    step(0, 1, 0, 3'b000, "R2 idle holds");
    step(1, 0, 0, 3'b000, "R2 start");
    step(1, 0, 0, 3'b000, "R3 active holds");
    step(0, 1, 0, 3'b000, "R3 finish");
    step(1, 1, 0, 3'b000, "R4 done to idle");
    step(1, 1, 0, 3'b000, "R2 start again");
    step(0, 1, 0, 3'b000, "R3 finish again");
    step(0, 0, 0, 3'b000, "R4 done to idle quiet");
    step(0, 0, 0, 3'b000, "R10 idle no recovery");

    for (int p = 0; p < 8; p++) begin
      step(0, 0, 1, 3'(p), "R9 inject load");
      step(0, 0, 0, 3'b000, "R5 R6 recover or proceed");
      step(0, 0, 0, 3'b000, "R7 flag drops");
      step(0, 0, 0, 3'b000, "R10 settle");
    end

    step(1, 0, 1, 3'b011, "R9 inject beats start");
    step(0, 0, 1, 3'b111, "R9 inject beats recovery");
    step(1, 1, 0, 3'b000, "R5 R6 recover ignores inputs");
    step(1, 0, 1, 3'b110, "R9 bit2 ignored compact");
    step(0, 1, 0, 3'b000, "R6 onehot 110 recovers");

    for (int k = 0; k < 260; k++) begin
      step(0, 0, 1, 3'b111, "R8 saturation inject");
      step(0, 0, 0, 3'b000, "R8 saturation recover");
    end
    step(1, 0, 0, 3'b000, "R10 normal after saturation");
    step(0, 1, 0, 3'b000, "R10 normal after saturation");
    step(0, 0, 0, 3'b000, "R4 done after saturation");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, got timeout, expected completion");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule